// File: doc/BRIEF.md
# Control Register Write Side-Effect Unit

This block owns a small set of processor control, extended-feature, segment-attribute and segment-base registers. It takes one indexed write per cycle. Before the value is committed it applies the architectural side effects of that write. The side effects are:

- switching long mode on or off;
- forcing a bit that must always read as one;
- keeping the effective segment bases consistent with the stored bases;
- storing the time-stamp counter as an offset from a free-running cycle count.

Most of these effects depend on which bits differ between the old value and the new value, not on the new value alone.

Around it sit an instruction and data translation cache and a mode decoder. This unit gives them single-cycle strobes: flush everything, flush non-global entries, and recompute the mode. It also flags any access to a control-register index that does not exist, and it drops that write. A combinational read port returns the committed state, with the time-stamp counter shown as offset plus the current count.

Top module: `cr_wr_ctl`

Index map:

| Index | Register |
|-------|----------|
| 0..15 | Control registers 0..15 |
| 16 | Extended features (bit 8 enables long mode, bit 10 shows it active) |
| 17 | Code-segment attributes (bit 0 is the long-mode bit) |
| 18 | Stack-segment attributes |
| 19 | Time-stamp counter |
| 20..27 | Stored bases, in the order ES, CS, SS, DS, FS, GS, TR, IDTR |
| 28..35 | Effective bases, in the same order (read-only) |

Every strobe is registered. It is high for exactly one cycle, the cycle after the clock edge that accepts the write.

## Requirements
- R1: After reset, control register 0 reads 0x10, all other mapped registers read 0, and all four strobes are low.
- R2: A write to control register 0 always stores bit 4 as 1, whatever value bit 4 of the written data has.
- R3: A control register 0 write that toggles bit 31 (paging) while index-16 bit 8 is set copies the new bit 31 into index-16 bit 10. If bit 8 is clear, bit 10 is left unchanged.
- R4: A control register 0 write that toggles bit 31 raises flush_all for one cycle after the accepting edge. A write that leaves bit 31 unchanged does not raise it.
- R5: Every write to control register 3 raises flush_nonglobal for one cycle after the accepting edge.
- R6: A control register 4 write raises flush_all only when it toggles at least one of bits 4, 5 or 7. Toggling other bits does not raise it.
- R7: Indices 1, 5..7 and 9..15 are illegal. A write to one of them or a read of one with rd_en set raises illegal_access for one cycle, and such a write changes no state. A legal write in the same cycle as an illegal read still commits, with its own strobes.
- R8: A code-segment attribute write that toggles bit 0 to 1 zeroes the ES, CS, SS and DS effective bases. Toggling it to 0 reloads those bases from their stored bases. A write with no toggle leaves them alone.
- R9: Writes to the ES, CS, SS or DS stored base update the matching effective base only when not in 64-bit mode (index-16 bit 10 and index-17 bit 0 are not both set). FS, GS, TR and IDTR base writes always update their effective base.
- R10: A time-stamp write of value D reads back D+1 in the cycle after the accepting edge and advances by one per clock thereafter.
- R11: Writes to indices 0, 4, 17 and 18 raise mode_recompute for one cycle after the accepting edge. No other write raises it.
- R12: Writes to the effective-base indices 28..35 or to indices 36 and above change nothing and raise no strobe. Reads of indices 36 and above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write value |
| rd_en | input | 1 | Read qualifier, used only for illegal-index flagging |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Committed value at rd_idx (combinational) |
| flush_all | output | 1 | Flush-all strobe to both translation caches |
| flush_nonglobal | output | 1 | Flush-non-global strobe to both translation caches |
| mode_recompute | output | 1 | Strobe telling the mode decoder to recompute |
| illegal_access | output | 1 | Illegal control-register index seen |

## Verification
A single control register 0 write that flips paging while long mode is enabled produces three effects in the same cycle: it sets the long-mode-active bit, raises flush_all and raises mode_recompute. The bench drives exactly that case and checks all three strobes together against one expected vector, and it checks the changed bit by reading back index 16. A second overlap is forced by reading an illegal index in the same cycle as a legal control register 3 write. Here illegal_access and flush_nonglobal must rise together, and a later read of index 3 must show that the write still committed.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int DW      = 64;
  localparam int IDX_W   = 6;
  localparam int NSEG    = 8;
  localparam int NSEG_LG = 4;                 // segments whose base is ignored in 64-bit mode
  localparam int SEG_W   = $clog2(NSEG);

  typedef logic [DW-1:0]    word_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IX_CR0  = idx_t'(0);
  localparam idx_t IX_CR2  = idx_t'(2);
  localparam idx_t IX_CR3  = idx_t'(3);
  localparam idx_t IX_CR4  = idx_t'(4);
  localparam idx_t IX_CR8  = idx_t'(8);
  localparam idx_t IX_CR15 = idx_t'(15);
  localparam idx_t IX_EFER = idx_t'(16);
  localparam idx_t IX_CSA  = idx_t'(17);
  localparam idx_t IX_SSA  = idx_t'(18);
  localparam idx_t IX_TSC  = idx_t'(19);
  localparam idx_t IX_BASE = idx_t'(20);
  localparam idx_t IX_EFF  = idx_t'(20 + NSEG);
  localparam idx_t IX_END  = idx_t'(20 + 2 * NSEG);

  localparam int B_PG  = 31;
  localparam int B_ET  = 4;
  localparam int B_LME = 8;
  localparam int B_LMA = 10;
  localparam int B_LM  = 0;
  localparam word_t CR4_FLUSH_MASK = word_t'(64'hB0);  // bits 4, 5, 7

  typedef enum logic [3:0] {
    C_NONE, C_ILLEGAL, C_CR0, C_CR3, C_CR4, C_PLAIN,
    C_EFER, C_CSA, C_SSA, C_TSC, C_BASE
  } cls_t;

  function automatic logic illegal_cr(idx_t i);
    return (i <= IX_CR15) &&
           (i == idx_t'(1) || (i > IX_CR4 && i < IX_CR8) || i > IX_CR8);
  endfunction

  function automatic word_t tsc_store(word_t v, word_t now);
    return v - now;
  endfunction

  function automatic word_t tsc_view(word_t off, word_t now);
    return off + now;
  endfunction

  function automatic word_t cr0_commit(word_t v);
    return v | (word_t'(1) << B_ET);
  endfunction
endpackage

// File: rtl/cr_idx_dec.sv
module cr_idx_dec import cr_pkg::*; (
  input  logic [IDX_W-1:0] idx,
  output cls_t             cls,
  output logic [SEG_W-1:0] seg
);
  assign seg = SEG_W'(idx - IX_BASE);

  always_comb begin
    if (illegal_cr(idx))                     cls = C_ILLEGAL;
    else if (idx == IX_CR0)                  cls = C_CR0;
    else if (idx == IX_CR3)                  cls = C_CR3;
    else if (idx == IX_CR4)                  cls = C_CR4;
    else if (idx == IX_CR2 || idx == IX_CR8) cls = C_PLAIN;
    else if (idx == IX_EFER)                 cls = C_EFER;
    else if (idx == IX_CSA)                  cls = C_CSA;
    else if (idx == IX_SSA)                  cls = C_SSA;
    else if (idx == IX_TSC)                  cls = C_TSC;
    else if (idx >= IX_BASE && idx < IX_EFF) cls = C_BASE;
    else                                     cls = C_NONE;
  end
endmodule

// File: rtl/cr_tsc.sv
module cr_tsc import cr_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] view
);
  word_t cnt_q, off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= '0;
    end else begin
      cnt_q <= cnt_q + word_t'(1);
      if (we) off_q <= tsc_store(wdata, cnt_q);
    end
  end

  assign view = tsc_view(off_q, cnt_q);
endmodule

// File: rtl/cr_segbase.sv
module cr_segbase import cr_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEG_W-1:0] seg,
  input  logic [DW-1:0]    wdata,
  input  logic             legacy_ok,
  input  logic             lm_on,
  input  logic             lm_off,
  output word_t [NSEG-1:0] base_q,
  output word_t [NSEG-1:0] eff_q
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    word_t b_r, e_r;
    logic  hit;
    assign hit       = we && (seg == SEG_W'(g));
    assign base_q[g] = b_r;
    assign eff_q[g]  = e_r;

    always_ff @(posedge clk) begin
      if (!rst_n)   b_r <= '0;
      else if (hit) b_r <= wdata;
    end

    if (g < NSEG_LG) begin : g_legacy
      always_ff @(posedge clk) begin
        if (!rst_n)                 e_r <= '0;
        else if (lm_on)             e_r <= '0;
        else if (lm_off)            e_r <= b_r;
        else if (hit && legacy_ok)  e_r <= wdata;
      end
    end else begin : g_always
      always_ff @(posedge clk) begin
        if (!rst_n)   e_r <= '0;
        else if (hit) e_r <= wdata;
      end
    end
  end
endmodule

// File: rtl/cr_wr_ctl.sv
module cr_wr_ctl import cr_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             flush_all,
  output logic             flush_nonglobal,
  output logic             mode_recompute,
  output logic             illegal_access
);
  cls_t             wcls, rcls;
  logic [SEG_W-1:0] wseg, rseg, eoff;

  cr_idx_dec u_wdec (.idx(wr_idx), .cls(wcls), .seg(wseg));
  cr_idx_dec u_rdec (.idx(rd_idx), .cls(rcls), .seg(rseg));

  word_t cr0_q, cr2_q, cr3_q, cr4_q, cr8_q, efer_q, csa_q, ssa_q;

  // named internal events
  logic we_cr0, we_cr3, we_cr4, we_efer, we_csa, we_ssa, we_plain, we_tsc, we_base;
  logic pg_toggle, lma_update, cr4_hit, lm_toggle, lm_on, lm_off, mode64, bad_wr, bad_rd;

  assign we_cr0   = wr_en && wcls == C_CR0;
  assign we_cr3   = wr_en && wcls == C_CR3;
  assign we_cr4   = wr_en && wcls == C_CR4;
  assign we_efer  = wr_en && wcls == C_EFER;
  assign we_csa   = wr_en && wcls == C_CSA;
  assign we_ssa   = wr_en && wcls == C_SSA;
  assign we_plain = wr_en && wcls == C_PLAIN;
  assign we_tsc   = wr_en && wcls == C_TSC;
  assign we_base  = wr_en && wcls == C_BASE;

  assign pg_toggle  = we_cr0 && (cr0_q[B_PG] ^ wr_data[B_PG]);
  assign lma_update = pg_toggle && efer_q[B_LME];
  assign cr4_hit    = we_cr4 && |((cr4_q ^ wr_data) & CR4_FLUSH_MASK);
  assign lm_toggle  = we_csa && (csa_q[B_LM] ^ wr_data[B_LM]);
  assign lm_on      = lm_toggle && wr_data[B_LM];
  assign lm_off     = lm_toggle && !wr_data[B_LM];
  assign mode64     = efer_q[B_LMA] && csa_q[B_LM];
  assign bad_wr     = wr_en && wcls == C_ILLEGAL;
  assign bad_rd     = rd_en && rcls == C_ILLEGAL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0_q <= cr0_commit('0);
      cr2_q <= '0; cr3_q <= '0; cr4_q <= '0; cr8_q <= '0;
      efer_q <= '0; csa_q <= '0; ssa_q <= '0;
      flush_all <= 1'b0; flush_nonglobal <= 1'b0;
      mode_recompute <= 1'b0; illegal_access <= 1'b0;
    end else begin
      flush_all       <= pg_toggle || cr4_hit;
      flush_nonglobal <= we_cr3;
      mode_recompute  <= we_cr0 || we_cr4 || we_csa || we_ssa;
      illegal_access  <= bad_wr || bad_rd;
      if (we_cr0) cr0_q <= cr0_commit(wr_data);
      if (we_cr3) cr3_q <= wr_data;
      if (we_cr4) cr4_q <= wr_data;
      if (we_plain) begin
        if (wr_idx == IX_CR2) cr2_q <= wr_data;
        else                  cr8_q <= wr_data;
      end
      if (we_efer)         efer_q <= wr_data;
      else if (lma_update) efer_q[B_LMA] <= wr_data[B_PG];
      if (we_csa) csa_q <= wr_data;
      if (we_ssa) ssa_q <= wr_data;
    end
  end

  word_t [NSEG-1:0] base_q, eff_q;
  word_t            tsc_now;

  cr_segbase u_seg (
    .clk(clk), .rst_n(rst_n), .we(we_base), .seg(wseg), .wdata(wr_data),
    .legacy_ok(!mode64), .lm_on(lm_on), .lm_off(lm_off),
    .base_q(base_q), .eff_q(eff_q)
  );

  cr_tsc u_tsc (.clk(clk), .rst_n(rst_n), .we(we_tsc), .wdata(wr_data), .view(tsc_now));

  assign eoff = SEG_W'(rd_idx - IX_EFF);

  always_comb begin
    rd_data = '0;
    case (rcls)
      C_CR0:   rd_data = cr0_q;
      C_CR3:   rd_data = cr3_q;
      C_CR4:   rd_data = cr4_q;
      C_PLAIN: rd_data = (rd_idx == IX_CR2) ? cr2_q : cr8_q;
      C_EFER:  rd_data = efer_q;
      C_CSA:   rd_data = csa_q;
      C_SSA:   rd_data = ssa_q;
      C_TSC:   rd_data = tsc_now;
      C_BASE:  rd_data = base_q[rseg];
      default: if (rd_idx >= IX_EFF && rd_idx < IX_END) rd_data = eff_q[eoff];
    endcase
  end
endmodule

// File: rtl/cr_wr_ctl_chk.sv
module cr_wr_ctl_chk import cr_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DW-1:0]    wr_data,
  input logic [DW-1:0]    cr0_q,
  input logic [DW-1:0]    cr4_q,
  input logic [DW-1:0]    efer_q,
  input logic             flush_all,
  input logic             flush_nonglobal,
  input logic             mode_recompute,
  input logic             illegal_access
);
  assert_et_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_CR0) |=> cr0_q[B_ET]);

  assert_lma_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_CR0 && efer_q[B_LME] && (wr_data[B_PG] != cr0_q[B_PG]))
    |=> efer_q[B_LMA] == $past(wr_data[B_PG]));

  assert_flush_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> ($past(wr_en) && ($past(wr_idx) == IX_CR0 || $past(wr_idx) == IX_CR4)));

  assert_cr3_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_CR3) |=> flush_nonglobal);

  assert_illegal_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && illegal_cr(wr_idx))
    |=> (illegal_access && $stable(cr0_q) && $stable(cr4_q) && $stable(efer_q)));

  assert_recompute_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_recompute |-> ($past(wr_en) &&
      ($past(wr_idx) == IX_CR0 || $past(wr_idx) == IX_CR4 ||
       $past(wr_idx) == IX_CSA || $past(wr_idx) == IX_SSA)));
endmodule

bind cr_wr_ctl cr_wr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .cr0_q(cr0_q), .cr4_q(cr4_q), .efer_q(efer_q),
  .flush_all(flush_all), .flush_nonglobal(flush_nonglobal),
  .mode_recompute(mode_recompute), .illegal_access(illegal_access)
);

// File: tb/cr_wr_ctl_tb.sv
`timescale 1ns/1ps
module cr_wr_ctl_tb;
  typedef logic [63:0] word;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] wr_idx = '0, rd_idx = '0;
  word wr_data = '0, rd_data;
  logic flush_all, flush_nonglobal, mode_recompute, illegal_access;

  always #4 clk = ~clk;   // 125 MHz

  cr_wr_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .flush_all(flush_all), .flush_nonglobal(flush_nonglobal),
    .mode_recompute(mode_recompute), .illegal_access(illegal_access)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues: expected {flush_all, flush_nonglobal, recompute, illegal}
  logic [3:0] exp_q[$];
  int         due_q[$];
  string      tag_q[$];

  // mirror model
  word m_cr0 = 64'h10, m_cr2 = 0, m_cr3 = 0, m_cr4 = 0, m_cr8 = 0;
  word m_efer = 0, m_csa = 0, m_ssa = 0;
  word m_b[8], m_e[8];

  task automatic chk(bit ok, string tag, word act, word exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_bad(int i);
    return i == 1 || (i >= 5 && i <= 7) || (i >= 9 && i <= 15);
  endfunction

  function automatic word model_rd(int i);
    case (i)
      0: return m_cr0;  2: return m_cr2;  3: return m_cr3;  4: return m_cr4;
      8: return m_cr8; 16: return m_efer; 17: return m_csa; 18: return m_ssa;
      default: begin
        if (i >= 20 && i < 28) return m_b[i-20];
        if (i >= 28 && i < 36) return m_e[i-28];
        return 64'h0;
      end
    endcase
  endfunction

  task automatic step(bit we, int wi, word d, bit re, int ri, logic [3:0] e, string tag);
    @(posedge clk); #1;
    wr_en = we; wr_idx = 6'(wi); wr_data = d; rd_en = re; rd_idx = 6'(ri);
    exp_q.push_back(e); due_q.push_back(cyc + 1); tag_q.push_back(tag);
  endtask

  task automatic wr(int i, word d, string tag, bit re = 0, int ri = 0);
    bit fa = 0, fng = 0, rc = 0, ill = 0;
    word t;
    if (is_bad(i)) ill = 1;
    else case (i)
      0: begin
        t = m_cr0 ^ d;
        if (t[31]) begin fa = 1; if (m_efer[8]) m_efer[10] = d[31]; end
        m_cr0 = d | 64'h10; rc = 1;
      end
      2: m_cr2 = d;
      3: begin m_cr3 = d; fng = 1; end
      4: begin t = m_cr4 ^ d; fa = |(t & 64'hB0); m_cr4 = d; rc = 1; end
      8: m_cr8 = d;
      16: m_efer = d;
      17: begin
        if (m_csa[0] != d[0])
          for (int k = 0; k < 4; k++) m_e[k] = d[0] ? 64'h0 : m_b[k];
        m_csa = d; rc = 1;
      end
      18: begin m_ssa = d; rc = 1; end
      default: if (i >= 20 && i < 28) begin
        m_b[i-20] = d;
        if (i >= 24 || !(m_efer[10] && m_csa[0])) m_e[i-20] = d;
      end
    endcase
    if (re && is_bad(ri)) ill = 1;
    step(1, i, d, re, ri, {fa, fng, rc, ill}, tag);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 4'b0, "idle");
  endtask

  task automatic rd_exp(int i, word e, string tag);
    step(0, 0, 0, 0, i, 4'b0, tag);
    #1 chk(rd_data === e, tag, rd_data, e);
  endtask

  task automatic rd(int i, string tag);
    rd_exp(i, model_rd(i), tag);
  endtask

  task automatic rd_ill(int i);
    step(0, 0, 0, 1, i, 4'b0001, "R7 illegal read");
  endtask

  // monitor: compares strobes against the scoreboard
  initial forever begin
    @(posedge clk); #4;
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      logic [3:0] e = exp_q.pop_front();
      logic [3:0] a = {flush_all, flush_nonglobal, mode_recompute, illegal_access};
      string      tg = tag_q.pop_front();
      void'(due_q.pop_front());
      chk(a === e, {tg, " strobes"}, word'(a), word'(e));
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_b[k] = 0; m_e[k] = 0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    #1 chk({flush_all, flush_nonglobal, mode_recompute, illegal_access} === 4'b0,
           "R1 strobes after reset", 0, 0);
    rd(0, "R1 cr0 reset"); rd(3, "R1 cr3 reset"); rd(16, "R1 efer reset");
    rd(17, "R1 csattr reset"); rd(20, "R1 base reset"); rd(28, "R1 eff reset");

    // R2: ET forced
    wr(0, 64'h0, "R2 cr0 write zero"); rd(0, "R2 et forced");
    wr(0, 64'h11, "R2 cr0 write et"); rd(0, "R2 et kept");

    // R3 + R4 + R11: paging on with long mode enabled
    wr(16, 64'h100, "R3 efer lme");
    wr(0, 64'h8000_0001, "R3 R4 R11 pg on with lme");
    rd(16, "R3 lma set");
    wr(0, 64'h8000_0003, "R4 no pg toggle");
    wr(0, 64'h1, "R4 pg off"); rd(16, "R3 lma cleared");
    wr(16, 64'h0, "R3 efer lme off");
    wr(0, 64'h8000_0001, "R4 pg on without lme"); rd(16, "R3 lma untouched");
    wr(0, 64'h1, "R4 pg off again");

    // R5
    wr(3, 64'hABC000, "R5 cr3 write"); rd(3, "R5 cr3 value");
    wr(3, 64'hABC000, "R5 cr3 same value");

    // R6
    wr(4, 64'h20, "R6 pae toggle");
    wr(4, 64'h21, "R6 non-flush bit");
    wr(4, 64'hA1, "R6 pge toggle");
    wr(4, 64'hB1, "R6 pse toggle"); rd(4, "R6 cr4 value");

    // R7: illegal writes dropped, illegal reads flagged, overlap with legal write
    wr(1, 64'hDEAD, "R7 write idx1");
    wr(5, 64'hDEAD, "R7 write idx5");
    wr(9, 64'hDEAD, "R7 write idx9");
    wr(15, 64'hDEAD, "R7 write idx15");
    rd(0, "R7 cr0 untouched"); rd(4, "R7 cr4 untouched");
    rd_ill(6);
    wr(3, 64'h5000, "R7 R5 cr3 with illegal read", 1, 7);
    rd(3, "R7 concurrent write committed");
    wr(2, 64'h77, "R7 cr2 legal"); wr(8, 64'h9, "R7 cr8 legal");
    rd(2, "R7 cr2 value"); rd(8, "R7 cr8 value");

    // R9 legacy mode, then R8 toggles
    wr(20, 64'h1000, "R9 es base legacy"); rd(28, "R9 es eff legacy");
    wr(23, 64'h1300, "R9 ds base legacy"); rd(31, "R9 ds eff legacy");
    wr(16, 64'h100, "R8 efer lme");
    wr(0, 64'h8000_0001, "R8 pg on");
    wr(17, 64'h1, "R8 R11 cs long on");
    rd(28, "R8 es eff zeroed"); rd(31, "R8 ds eff zeroed");
    wr(17, 64'h3, "R8 cs no toggle"); rd(28, "R8 es eff still zero");
    wr(20, 64'h2000, "R9 es base in 64-bit"); rd(28, "R9 es eff held");
    rd(20, "R9 es base stored");
    wr(24, 64'h3000, "R9 fs base in 64-bit"); rd(32, "R9 fs eff updated");
    wr(27, 64'h3700, "R9 idtr base"); rd(35, "R9 idtr eff");
    wr(17, 64'h2, "R8 cs long off");
    rd(28, "R8 es eff restored"); rd(31, "R8 ds eff restored");
    wr(22, 64'h4400, "R9 ss base after lm off"); rd(30, "R9 ss eff updated");
    wr(18, 64'h5, "R11 ss attr"); rd(18, "R11 ss value");

    // R10
    wr(19, 64'h1_0000_0000, "R10 tsc write");
    rd_exp(19, 64'h1_0000_0001, "R10 tsc next cycle");
    repeat (5) idle();
    rd_exp(19, 64'h1_0000_0007, "R10 tsc advanced");

    // R12
    wr(29, 64'hFFFF, "R12 eff write dropped"); rd(29, "R12 eff unchanged");
    wr(40, 64'hFFFF, "R12 reserved write"); rd_exp(40, 64'h0, "R12 reserved read");
    rd(0, "R12 cr0 unchanged");

    idle(); idle();
    @(posedge clk); #6;
    finish_run();
  end
endmodule